// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block is a small bus master that brings a phase-locked loop out of reset into a running, locked state. It drives a 32-bit register port with one request outstanding at a time. Divider values and the internal reference frequency are computed elsewhere and arrive precomputed. The block puts the input divider, the feedback multiplier and up to four output post-dividers into two configuration words. It then read-modify-writes the control word so that the outputs stay gated and bypassed, and fires a self-clearing trigger register.

After the trigger, the block polls until the trigger clears and until the loop reports lock. Each wait uses a fast burst of back-to-back reads and then a slower, paced poll that is bounded by a cycle budget. The block then rewrites the control word to release the bypass and to enable only the outputs whose divider is nonzero. It waits for the acknowledge bit of each enabled output and reports completion with an error code. A second entry point only waits for the loop's reset-done status bit.

Top module: `pll_prog_seq`

## Requirements
- R1: On `start` from idle, the writes go to offsets 0x0C, 0x14, 0x10 and 0x08, in that order, with a read of 0x10 before the write to 0x10. After lock, 0x10 is read again and then written. Every write to the trigger register 0x08 carries the value 1.
- R2: The word written to 0x0C holds: bit 0 = the stop flag (set while parameter HAS_STOP is nonzero); bits 8:1 = N−1; bits 19:9 = M; bits 25:20 = encoding of output 0; bits 31:26 = encoding of output 1. A divider is encoded as value−1, or as 0 when the divider is 0.
- R3: The word written to 0x14 holds the encoding of output 2 in bits 5:0 and of output 3 in bits 11:6. All other bits are 0.
- R4: The first write to 0x10 is the value just read with these changes: bits 4:1 = frequency code; bit 13 = 1; bit 14 = 0; bit 20 = 1; bits 22:21 = 3; bits 16, 18, 23 and 25 = 0. All other bits are kept. The frequency code is 3 below 1000 kHz, 4 below 1250, 5 below 1500, 6 below 1750, and 7 otherwise.
- R5: After the trigger write, 0x08 is read until bit 0 reads 0. After FAST_POLLS misses in a row, reads are paced SLOW_GAP idle cycles apart. When SLOW_BUDGET paced cycles have passed and a read still misses, the run ends with errCode 1 and makes no further write.
- R6: After the trigger clears, status 0x04 is read until bit 1 (locked) is 1. This wait uses the same fast then paced scheme. Its timeout ends the run with errCode 2 and makes no further write.
- R7: The second write to 0x10 is the re-read value with these changes: bit 14 = 1; bit 20 = 0; bits 16, 18, 23 and 25 (outputs 0 to 3) each set only when that output's divider is nonzero. All other bits are kept.
- R8: Status is then read until every acknowledge bit of an enabled output is 1. The acknowledge bits are 7, 8, 10 and 11 for outputs 0 to 3. Success gives errCode 0. After ACK_POLLS reads without success, the run ends with errCode 3. With no output enabled, the first read ends the run.
- R9: A `rstChkStart` pulse from idle reads status until bit 0 is 1 and issues no write. It ends with errCode 0 on success. A timeout, using the fast then paced scheme, gives errCode 2.
- R10: While `regReq` is high and `regAck` is low, address, write enable and write data stay stable. `regReq` is low whenever `busy` is low.
- R11: After reset, busy, done, regReq and errCode are 0. `busy` rises the cycle after a start. `done` is a one-cycle pulse, after which busy is low. errCode holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the full programming sequence (idle only) |
| rstChkStart | input | 1 | Begin the reset-done wait (idle only) |
| divN | input | 8 | Input divider N (1 or more) |
| divM | input | 11 | Feedback multiplier M |
| postDivs | input | 24 | Four 6-bit output dividers, output 0 in the low bits; 0 means unused |
| fintKhz | input | 16 | Internal reference frequency in kHz |
| regReq | output | 1 | Register access request |
| regWe | output | 1 | 1 = write, 0 = read |
| regAddr | output | 8 | Register byte offset |
| regWdata | output | 32 | Write data |
| regAck | input | 1 | One-cycle completion of the current access |
| regRdata | input | 32 | Read data, valid with regAck |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | 0 ok, 1 trigger timeout, 2 lock/reset-done timeout, 3 acknowledge timeout |

## Verification
Random divider sets, with about a quarter of the outputs unused, check the word layouts and the enable masks against the acknowledge poll. Frequencies on each side of every code threshold separate the frequency-code boundaries. One trigger that clears only after the fast burst shows that paced polling recovers rather than failing. Runs where the trigger never clears, lock never comes, acknowledges never come and reset-done never comes each separate one error code and the write count where the run stops. A run with no outputs in use shows that an empty acknowledge mask ends after a single read.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_OUT = 4;

  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_GO   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG1 = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CFG2 = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG3 = 8'h14;

  localparam int STAT_RST   = 0;
  localparam int STAT_LOCK  = 1;
  localparam int C2_FSEL_LO = 1;
  localparam int C2_REFEN   = 13;
  localparam int C2_INEN    = 14;
  localparam int C2_BYP     = 20;
  localparam int C2_RSEL_LO = 21;

  localparam int EN_POS  [NUM_OUT] = '{16, 18, 23, 25};
  localparam int ACK_POS [NUM_OUT] = '{7, 8, 10, 11};

  typedef enum logic [3:0] {
    OP_NONE, OP_CFG1, OP_CFG3, OP_RD_CFG2, OP_WR_CFG2A,
    OP_WR_CFG2B, OP_GO, OP_RD_GO, OP_RD_STAT
  } regOpE;

  typedef enum logic [1:0] {PK_GO, PK_LOCK, PK_ACK, PK_RST} pollKindE;

  typedef enum logic [1:0] {ERR_NONE, ERR_GO, ERR_LOCK, ERR_ACK} errCodeE;

  typedef struct packed {
    regOpE    op;
    pollKindE kind;
    logic     loadIn;
    logic     capRd;
    logic     pollClr;
    logic     pollMiss;
    logic     slowRun;
    logic     gapRun;
  } seqStrobeT;
endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int N_W         = 8,
  parameter int M_W         = 11,
  parameter int PD_W        = 6,
  parameter int FINT_W      = 16,
  parameter int FAST_POLLS  = 100,
  parameter int ACK_POLLS   = 100,
  parameter int SLOW_GAP    = 32,
  parameter int SLOW_BUDGET = 4000,
  parameter int HAS_STOP    = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobeT                 stb,
  input  logic [N_W-1:0]            divN,
  input  logic [M_W-1:0]            divM,
  input  logic [NUM_OUT*PD_W-1:0]   postDivs,
  input  logic [FINT_W-1:0]         fintKhz,
  input  logic [DATA_W-1:0]         regRdata,
  output logic [ADDR_W-1:0]         regAddr,
  output logic                      regWe,
  output logic [DATA_W-1:0]         regWdata,
  output logic                      pollHit,
  output logic                      fastLast,
  output logic                      ackLast,
  output logic                      budgetOver,
  output logic                      gapDone
);
  localparam int POLL_MAX = (FAST_POLLS > ACK_POLLS) ? FAST_POLLS : ACK_POLLS;
  localparam int CNT_W    = $clog2(POLL_MAX + 1);
  localparam int BUD_W    = $clog2(SLOW_BUDGET + 1);
  localparam int GAP_W    = $clog2(SLOW_GAP + 1);
  localparam int M_LO     = N_W + 1;
  localparam int PD0_LO   = M_LO + M_W;
  localparam int PD1_LO   = PD0_LO + PD_W;

  logic [N_W-1:0]          nQ;
  logic [M_W-1:0]          mQ;
  logic [NUM_OUT*PD_W-1:0] pdQ;
  logic [FINT_W-1:0]       fintQ;
  logic [DATA_W-1:0]       cfg2Q;
  logic [CNT_W-1:0]        pollCnt;
  logic [BUD_W-1:0]        budCnt;
  logic [GAP_W-1:0]        gapCnt;

  logic [PD_W-1:0]         pdEnc [NUM_OUT];
  logic [NUM_OUT-1:0]      used;
  logic [DATA_W-1:0]       fieldMask, enMask, ackMask;
  logic [DATA_W-1:0]       cfg1W, cfg3W, cfg2A, cfg2B, clrA;

  function automatic logic [3:0] fselCode(input logic [FINT_W-1:0] f);
    if (f < FINT_W'(1000))      return 4'd3;
    else if (f < FINT_W'(1250)) return 4'd4;
    else if (f < FINT_W'(1500)) return 4'd5;
    else if (f < FINT_W'(1750)) return 4'd6;
    else                        return 4'd7;
  endfunction

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      assign used[g]  = |pdQ[g*PD_W +: PD_W];
      assign pdEnc[g] = used[g] ? pdQ[g*PD_W +: PD_W] - 1'b1 : '0;
    end
  endgenerate

  always_comb begin
    fieldMask = '0;
    enMask    = '0;
    ackMask   = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      fieldMask[EN_POS[i]] = 1'b1;
      if (used[i]) begin
        enMask[EN_POS[i]]   = 1'b1;
        ackMask[ACK_POS[i]] = 1'b1;
      end
    end
  end

  always_comb begin
    cfg1W = DATA_W'(HAS_STOP != 0)
          | (DATA_W'(N_W'(nQ - 1'b1)) << 1)
          | (DATA_W'(mQ) << M_LO)
          | (DATA_W'(pdEnc[0]) << PD0_LO)
          | (DATA_W'(pdEnc[1]) << PD1_LO);
    cfg3W = DATA_W'(pdEnc[2]) | (DATA_W'(pdEnc[3]) << PD_W);

    clrA = fieldMask;
    clrA[C2_FSEL_LO +: 4] = '1;
    clrA[C2_REFEN]        = 1'b1;
    clrA[C2_INEN]         = 1'b1;
    clrA[C2_BYP]          = 1'b1;
    clrA[C2_RSEL_LO +: 2] = '1;
    cfg2A = cfg2Q & ~clrA;
    cfg2A[C2_FSEL_LO +: 4] = fselCode(fintQ);
    cfg2A[C2_REFEN]        = 1'b1;
    cfg2A[C2_BYP]          = 1'b1;
    cfg2A[C2_RSEL_LO +: 2] = 2'b11;

    cfg2B = (cfg2Q & ~fieldMask) | enMask;
    cfg2B[C2_INEN] = 1'b1;
    cfg2B[C2_BYP]  = 1'b0;
  end

  always_comb begin
    regAddr  = OFS_STAT;
    regWe    = 1'b0;
    regWdata = '0;
    unique case (stb.op)
      OP_CFG1:     begin regAddr = OFS_CFG1; regWe = 1'b1; regWdata = cfg1W; end
      OP_CFG3:     begin regAddr = OFS_CFG3; regWe = 1'b1; regWdata = cfg3W; end
      OP_RD_CFG2:  regAddr = OFS_CFG2;
      OP_WR_CFG2A: begin regAddr = OFS_CFG2; regWe = 1'b1; regWdata = cfg2A; end
      OP_WR_CFG2B: begin regAddr = OFS_CFG2; regWe = 1'b1; regWdata = cfg2B; end
      OP_GO:       begin regAddr = OFS_GO; regWe = 1'b1; regWdata = DATA_W'(1); end
      OP_RD_GO:    regAddr = OFS_GO;
      default:     regAddr = OFS_STAT;
    endcase
  end

  always_comb begin
    unique case (stb.kind)
      PK_GO:   pollHit = ~regRdata[0];
      PK_LOCK: pollHit = regRdata[STAT_LOCK];
      PK_RST:  pollHit = regRdata[STAT_RST];
      default: pollHit = (regRdata & ackMask) == ackMask;
    endcase
  end

  assign fastLast   = pollCnt == CNT_W'(FAST_POLLS - 1);
  assign ackLast    = pollCnt == CNT_W'(ACK_POLLS - 1);
  assign budgetOver = budCnt >= BUD_W'(SLOW_BUDGET - 1);
  assign gapDone    = gapCnt == GAP_W'(SLOW_GAP - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nQ      <= '0;
      mQ      <= '0;
      pdQ     <= '0;
      fintQ   <= '0;
      cfg2Q   <= '0;
      pollCnt <= '0;
      budCnt  <= '0;
      gapCnt  <= '0;
    end else begin
      if (stb.loadIn) begin
        nQ    <= divN;
        mQ    <= divM;
        pdQ   <= postDivs;
        fintQ <= fintKhz;
      end
      if (stb.capRd) cfg2Q <= regRdata;
      if (stb.pollClr)       pollCnt <= '0;
      else if (stb.pollMiss) pollCnt <= pollCnt + 1'b1;
      if (stb.pollClr)                   budCnt <= '0;
      else if (stb.slowRun && !budgetOver) budCnt <= budCnt + 1'b1;
      if (!stb.gapRun) gapCnt <= '0;
      else             gapCnt <= gapCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rstChkStart,
  input  logic      regAck,
  input  logic      pollHit,
  input  logic      fastLast,
  input  logic      ackLast,
  input  logic      budgetOver,
  input  logic      gapDone,
  output seqStrobeT stb,
  output logic      regReq,
  output logic      busy,
  output logic      done,
  output logic [1:0] errCode
);
  typedef enum logic [3:0] {
    S_IDLE, S_CFG1, S_CFG3, S_RD2A, S_WR2A, S_GO,
    S_POLL, S_GAP, S_RD2B, S_WR2B, S_END
  } stateE;

  stateE    state, stNext;
  pollKindE kindQ, kindNext;
  logic     slowQ, slowNext;
  errCodeE  errQ, errNext;

  always_comb begin
    stNext   = state;
    kindNext = kindQ;
    slowNext = slowQ;
    errNext  = errQ;
    stb         = '0;
    stb.op      = OP_NONE;
    stb.kind    = kindQ;
    stb.slowRun = slowQ && (state == S_POLL || state == S_GAP);
    stb.gapRun  = state == S_GAP;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stNext     = S_CFG1;
          stb.loadIn = 1'b1;
          errNext    = ERR_NONE;
        end else if (rstChkStart) begin
          stNext      = S_POLL;
          kindNext    = PK_RST;
          slowNext    = 1'b0;
          stb.pollClr = 1'b1;
          errNext     = ERR_NONE;
        end
      end
      S_CFG1: begin
        stb.op = OP_CFG1;
        if (regAck) stNext = S_CFG3;
      end
      S_CFG3: begin
        stb.op = OP_CFG3;
        if (regAck) stNext = S_RD2A;
      end
      S_RD2A: begin
        stb.op    = OP_RD_CFG2;
        stb.capRd = regAck;
        if (regAck) stNext = S_WR2A;
      end
      S_WR2A: begin
        stb.op = OP_WR_CFG2A;
        if (regAck) stNext = S_GO;
      end
      S_GO: begin
        stb.op = OP_GO;
        if (regAck) begin
          stNext      = S_POLL;
          kindNext    = PK_GO;
          slowNext    = 1'b0;
          stb.pollClr = 1'b1;
        end
      end
      S_POLL: begin
        stb.op = (kindQ == PK_GO) ? OP_RD_GO : OP_RD_STAT;
        if (regAck) begin
          if (pollHit) begin
            unique case (kindQ)
              PK_GO: begin
                kindNext    = PK_LOCK;
                slowNext    = 1'b0;
                stb.pollClr = 1'b1;
              end
              PK_LOCK: stNext = S_RD2B;
              default: begin
                stNext  = S_END;
                errNext = ERR_NONE;
              end
            endcase
          end else begin
            stb.pollMiss = 1'b1;
            if (kindQ == PK_ACK) begin
              if (ackLast) begin
                stNext  = S_END;
                errNext = ERR_ACK;
              end
            end else if (!slowQ) begin
              if (fastLast) begin
                slowNext = 1'b1;
                stNext   = S_GAP;
              end
            end else if (budgetOver) begin
              stNext  = S_END;
              errNext = (kindQ == PK_GO) ? ERR_GO : ERR_LOCK;
            end else begin
              stNext = S_GAP;
            end
          end
        end
      end
      S_GAP: if (gapDone) stNext = S_POLL;
      S_RD2B: begin
        stb.op    = OP_RD_CFG2;
        stb.capRd = regAck;
        if (regAck) stNext = S_WR2B;
      end
      S_WR2B: begin
        stb.op = OP_WR_CFG2B;
        if (regAck) begin
          stNext      = S_POLL;
          kindNext    = PK_ACK;
          slowNext    = 1'b0;
          stb.pollClr = 1'b1;
        end
      end
      S_END:   stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= PK_GO;
      slowQ <= 1'b0;
      errQ  <= ERR_NONE;
    end else begin
      state <= stNext;
      kindQ <= kindNext;
      slowQ <= slowNext;
      errQ  <= errNext;
    end
  end

  assign regReq  = stb.op != OP_NONE;
  assign busy    = state != S_IDLE;
  assign done    = state == S_END;
  assign errCode = errQ;
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int N_W         = 8,
  parameter int M_W         = 11,
  parameter int PD_W        = 6,
  parameter int FINT_W      = 16,
  parameter int FAST_POLLS  = 100,
  parameter int ACK_POLLS   = 100,
  parameter int SLOW_GAP    = 32,
  parameter int SLOW_BUDGET = 4000,
  parameter int HAS_STOP    = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    rstChkStart,
  input  logic [N_W-1:0]          divN,
  input  logic [M_W-1:0]          divM,
  input  logic [4*PD_W-1:0]       postDivs,
  input  logic [FINT_W-1:0]       fintKhz,
  output logic                    regReq,
  output logic                    regWe,
  output logic [7:0]              regAddr,
  output logic [31:0]             regWdata,
  input  logic                    regAck,
  input  logic [31:0]             regRdata,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              errCode
);
  seqStrobeT stb;
  logic pollHit, fastLast, ackLast, budgetOver, gapDone;

  pll_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rstChkStart(rstChkStart),
    .regAck(regAck), .pollHit(pollHit), .fastLast(fastLast), .ackLast(ackLast),
    .budgetOver(budgetOver), .gapDone(gapDone), .stb(stb), .regReq(regReq),
    .busy(busy), .done(done), .errCode(errCode)
  );

  pll_seq_dp #(
    .N_W(N_W), .M_W(M_W), .PD_W(PD_W), .FINT_W(FINT_W),
    .FAST_POLLS(FAST_POLLS), .ACK_POLLS(ACK_POLLS), .SLOW_GAP(SLOW_GAP),
    .SLOW_BUDGET(SLOW_BUDGET), .HAS_STOP(HAS_STOP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .divN(divN), .divM(divM),
    .postDivs(postDivs), .fintKhz(fintKhz), .regRdata(regRdata),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .pollHit(pollHit),
    .fastLast(fastLast), .ackLast(ackLast), .budgetOver(budgetOver), .gapDone(gapDone)
  );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regReq,
  input logic        regWe,
  input logic [7:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        regAck,
  input logic        busy,
  input logic        done
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWe) && $stable(regWdata)); // R10
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !regReq); // R10
  AST_GO_WRITE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && regAddr == 8'h08 |-> regWdata == 32'd1); // R1
  AST_BYPASS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && regAddr == 8'h10 && regWdata[20] |->
      !regWdata[16] && !regWdata[18] && !regWdata[23] && !regWdata[25] &&
      regWdata[13] && !regWdata[14]); // R4
  AST_RUN_INPUT_ON: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && regAddr == 8'h10 && !regWdata[20] |-> regWdata[14]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R11
endmodule

bind pll_prog_seq pll_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regAck(regAck), .busy(busy), .done(done)
);

// File: tb/pll_prog_seq_bench.sv
module pll_prog_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FAST   = 100;
  localparam int ACKP   = 100;
  localparam int GAP    = 32;
  localparam int BUDGET = 4000;
  localparam int NEVER  = 1000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        rstChkStart = 1'b0;
  logic [7:0]  divN = 8'd1;
  logic [10:0] divM = '0;
  logic [23:0] postDivs = '0;
  logic [15:0] fintKhz = '0;
  logic        regReq, regWe, busy, done;
  logic [7:0]  regAddr;
  logic [31:0] regWdata;
  logic        regAck = 1'b0;
  logic [31:0] regRdata = '0;
  logic [1:0]  errCode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_prog_seq #(.FAST_POLLS(FAST), .ACK_POLLS(ACKP), .SLOW_GAP(GAP), .SLOW_BUDGET(BUDGET))
  u_pll_prog_seq (
    .clk(clk), .rstN(rstN), .start(start), .rstChkStart(rstChkStart),
    .divN(divN), .divM(divM), .postDivs(postDivs), .fintKhz(fintKhz),
    .regReq(regReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regRdata(regRdata), .busy(busy), .done(done), .errCode(errCode)
  );

  // register model of the PLL
  logic [31:0] mCfg1, mCfg2, mCfg3;
  logic [31:0] cfg2Log [2];
  logic [7:0]  wrLog [8];
  int wrCount, cfg2Writes, goHold, goSeen, goReads, lockAfter, lockReads;
  int ackReads, statReads, rstAfter, lat, latCnt;
  bit goArmed, goCleared, finalWritten, ackBroken;

  task automatic clearModel();
    wrCount = 0; cfg2Writes = 0; goSeen = 0; goReads = 0; lockReads = 0;
    ackReads = 0; statReads = 0; latCnt = 0; goArmed = 0; goCleared = 0;
    finalWritten = 0; ackBroken = 0; goHold = 0; lockAfter = 0; rstAfter = 0;
    mCfg1 = '0; mCfg3 = '0; mCfg2 = '0; cfg2Log[0] = '0; cfg2Log[1] = '0;
    for (int i = 0; i < 8; i++) wrLog[i] = '0;
    lat = $urandom_range(0, 3);
  endtask

  always @(negedge clk) begin
    if (regAck) regAck = 1'b0;
    else if (regReq) begin
      if (latCnt < lat) latCnt++;
      else begin
        latCnt = 0;
        regRdata = '0;
        if (regWe) begin
          if (wrCount < 8) wrLog[wrCount] = regAddr;
          wrCount++;
          case (regAddr)
            8'h0C: mCfg1 = regWdata;
            8'h14: mCfg3 = regWdata;
            8'h10: begin
              mCfg2 = regWdata;
              if (cfg2Writes < 2) cfg2Log[cfg2Writes] = regWdata;
              cfg2Writes++;
              if (!regWdata[20]) finalWritten = 1;
            end
            8'h08: if (regWdata[0]) begin goArmed = 1; goSeen = 0; end
            default: ;
          endcase
        end else begin
          case (regAddr)
            8'h08: begin
              goReads++;
              regRdata[0] = goArmed && (goSeen < goHold);
              goSeen++;
              if (goArmed && !regRdata[0]) begin goArmed = 0; goCleared = 1; end
            end
            8'h04: begin
              statReads++;
              if (finalWritten) ackReads++;
              if (goCleared && !finalWritten) lockReads++;
              regRdata[0] = statReads > rstAfter;
              regRdata[1] = goCleared && (lockReads > lockAfter);
              if (!ackBroken) begin
                regRdata[7]  = mCfg2[16];
                regRdata[8]  = mCfg2[18];
                regRdata[10] = mCfg2[23];
                regRdata[11] = mCfg2[25];
              end
            end
            8'h10: regRdata = mCfg2;
            default: ;
          endcase
        end
        regAck = 1'b1;
      end
    end
  end

  // expected values from the requirements
  function automatic int enc(int p);
    return (p == 0) ? 0 : (p - 1) & 63;
  endfunction

  function automatic logic [3:0] fsel(int f);
    if (f < 1000) return 4'd3;
    if (f < 1250) return 4'd4;
    if (f < 1500) return 4'd5;
    if (f < 1750) return 4'd6;
    return 4'd7;
  endfunction

  function automatic logic [31:0] eCfg1(int n, int m, int p0, int p1);
    return 32'd1 | (32'(n - 1) << 1) | (32'(m) << 9) | (32'(enc(p0)) << 20) | (32'(enc(p1)) << 26);
  endfunction

  function automatic logic [31:0] eCfg3(int p2, int p3);
    return 32'(enc(p2)) | (32'(enc(p3)) << 6);
  endfunction

  function automatic logic [31:0] eCfg2A(logic [31:0] prev, int f);
    logic [31:0] v = prev;
    v[4:1] = fsel(f); v[13] = 1; v[14] = 0; v[16] = 0; v[18] = 0;
    v[20] = 1; v[22:21] = 2'b11; v[23] = 0; v[25] = 0;
    return v;
  endfunction

  function automatic logic [31:0] eCfg2B(logic [31:0] prev, int p0, int p1, int p2, int p3);
    logic [31:0] v = prev;
    v[14] = 1; v[20] = 0; v[16] = p0 != 0; v[18] = p1 != 0; v[23] = p2 != 0; v[25] = p3 != 0;
    return v;
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic finishRun(string req, logic [1:0] expErr, bit ok);
    check(req, "completed", 32'(ok), 32'd1);
    if (!ok) begin
      rstN = 0; @(negedge clk); rstN = 1;
      return;
    end
    check(req, "errCode", 32'(errCode), 32'(expErr));
    @(negedge clk);
    check("R11", "done pulse ends", 32'(done), 32'd0);
    check("R11", "idle after done", 32'(busy), 32'd0);
    check("R11", "errCode held", 32'(errCode), 32'(expErr));
  endtask

  task automatic runProg(int n, int m, int p0, int p1, int p2, int p3, int f,
                         int gh, int la, bit ab, logic [1:0] expErr);
    bit ok;
    logic [31:0] seed;
    clearModel();
    goHold = gh; lockAfter = la; ackBroken = ab;
    seed = $urandom;
    mCfg2 = seed;
    divN = 8'(n); divM = 11'(m); fintKhz = 16'(f);
    postDivs = {6'(p3), 6'(p2), 6'(p1), 6'(p0)};
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check("R11", "busy after start", 32'(busy), 32'd1);
    waitDone(ok);
    case (expErr)
      2'd0: begin
        check("R1", "write count", 32'(wrCount), 32'd5);
        check("R1", "write 1 addr", 32'(wrLog[0]), 32'h0C);
        check("R1", "write 2 addr", 32'(wrLog[1]), 32'h14);
        check("R1", "write 3 addr", 32'(wrLog[2]), 32'h10);
        check("R1", "write 4 addr", 32'(wrLog[3]), 32'h08);
        check("R1", "write 5 addr", 32'(wrLog[4]), 32'h10);
        check("R2", "config1 word", mCfg1, eCfg1(n, m, p0, p1));
        check("R3", "config3 word", mCfg3, eCfg3(p2, p3));
        check("R4", "gated control word", cfg2Log[0], eCfg2A(seed, f));
        check("R7", "running control word", cfg2Log[1],
              eCfg2B(eCfg2A(seed, f), p0, p1, p2, p3));
        if (p0 == 0 && p1 == 0 && p2 == 0 && p3 == 0)
          check("R8", "single ack read when no output", 32'(ackReads), 32'd1);
      end
      2'd1: begin
        check("R5", "no write after trigger timeout", 32'(wrCount), 32'd4);
        check("R5", "paced reads beyond fast burst", 32'(goReads > FAST), 32'd1);
      end
      2'd2: begin
        check("R6", "no write after lock timeout", 32'(wrCount), 32'd4);
        check("R6", "paced lock reads beyond fast burst", 32'(lockReads > FAST), 32'd1);
      end
      default: check("R8", "ack poll read count", 32'(ackReads), 32'(ACKP));
    endcase
    finishRun(expErr == 0 ? "R8" : (expErr == 1 ? "R5" : (expErr == 2 ? "R6" : "R8")), expErr, ok);
  endtask

  task automatic runRst(int ra, logic [1:0] expErr);
    bit ok;
    clearModel();
    rstAfter = ra;
    @(negedge clk) rstChkStart = 1;
    @(negedge clk) rstChkStart = 0;
    waitDone(ok);
    check("R9", "no writes in reset-done wait", 32'(wrCount), 32'd0);
    if (expErr == 0) check("R9", "status reads until ready", 32'(statReads), 32'(ra + 1));
    finishRun("R9", expErr, ok);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fb [8] = '{999, 1000, 1249, 1250, 1499, 1500, 1749, 1750};
    void'($urandom(32'd4242));
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11", "reset busy", 32'(busy), 32'd0);
    check("R11", "reset done", 32'(done), 32'd0);
    check("R11", "reset regReq", 32'(regReq), 32'd0);
    check("R11", "reset errCode", 32'(errCode), 32'd0);

    // random programming runs
    for (int k = 0; k < 14; k++) begin
      int p [4];
      for (int j = 0; j < 4; j++)
        p[j] = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 63);
      runProg($urandom_range(1, 255), $urandom_range(0, 2047), p[0], p[1], p[2], p[3],
              $urandom_range(500, 2499), $urandom_range(0, 5), $urandom_range(0, 5), 0, 2'd0);
    end
    // frequency code boundaries (R4)
    for (int k = 0; k < 8; k++)
      runProg(1, 100, 5, 0, 7, 0, fb[k], 0, 0, 0, 2'd0);
    // extreme divider values (R2, R3)
    runProg(255, 2047, 63, 1, 63, 1, 2000, 1, 1, 0, 2'd0);
    // no outputs in use (R8)
    runProg(4, 300, 0, 0, 0, 0, 1100, 0, 0, 0, 2'd0);
    // trigger clears only in the paced phase (R5)
    runProg(3, 200, 2, 3, 4, 5, 1300, FAST + 2, 0, 0, 2'd0);
    // lock arrives only in the paced phase (R6)
    runProg(3, 200, 2, 0, 0, 5, 1600, 0, FAST + 1, 0, 2'd0);
    // timeouts
    runProg(2, 50, 1, 2, 3, 4, 900, NEVER, 0, 0, 2'd1);
    runProg(2, 50, 1, 2, 3, 4, 900, 0, NEVER, 0, 2'd2);
    runProg(2, 50, 1, 2, 3, 4, 900, 0, 0, 1, 2'd3);
    // reset-done wait (R9)
    runRst(0, 2'd0);
    runRst(7, 2'd0);
    runRst(NEVER, 2'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule